// File: doc/BRIEF.md
# Memory-Mapped Device Select Decoder

This block is the glue between a processor's shared address and data buses and a set of peripheral devices reached through memory-mapped I/O. The most significant address bit marks a cycle as an I/O access rather than a memory access. A select field just below it names one device. The lowest address bits carry control information for devices that have no isolation guard of their own.

Each device is either guarded or unguarded, as set by a parameter mask. A guarded device receives a guard-enable whenever it is addressed, so every other device stays isolated. An unguarded device is forced to share the bus. For each such device the block keeps a data holding register that is loaded on a write strobe, and it drives a tri-state output enable for reads. The select field encoding is fixed when the block is elaborated: one-hot, plain binary, or a table of prefix-free codes of different lengths.

Top module: `mmio_sel_decoder`

## Requirements
- R1: When address bit IO_BIT (bit 15 by default) is 0, no guard-enable, no output enable, no error and no holding-register load occur, and dev_ctrl reads 0.
- R2: In one-hot mode the select field is addr[14:11] for four devices, and bit 11+i alone selects device i. A field with zero bits set or with more than one bit set is an unknown code.
- R3: In binary mode with three devices the select field is addr[14:13], and value i selects device i. The value 3 is an unknown code.
- R4: In prefix mode the select field is addr[14:11], read from bit 14 downward. The codes are "0" for device 0, "10" for device 1, "110" for device 2 and "1110" for device 3. The pattern 1111 is an unknown code.
- R5: guard_en[i] is 1 only when device i is addressed and is marked guarded in GUARD_MASK (default 4'b0101: devices 0 and 2). At most one enable of any kind is active in a cycle.
- R6: dev_ctrl equals addr[3:0] when the addressed device is unguarded. In every other case it is 0.
- R7: When wr_stb is 1 and unguarded device i is addressed, wdata appears on shr_q[8i+7:8i] after the next rising clock edge.
- R8: A device's holding register keeps its value in any cycle where that device is not written: on reads, idle cycles, non-I/O cycles, writes to other devices and unknown codes.
- R9: shr_oe[i] is 1 exactly when rd_stb is 1 and unguarded device i is addressed. It is never 1 for a guarded device.
- R10: An I/O access with an unknown select code raises dec_err. No guard-enable, output enable, control output or register load occurs.
- R11: After synchronous reset every holding register reads 0. The shr_q slices of guarded devices always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Processor address bus |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| wdata | input | DATA_W | Processor write data |
| guard_en | output | NUM_DEV | Guard enable per device (guarded devices only) |
| dev_ctrl | output | CTRL_W | Control field for the addressed unguarded device |
| shr_oe | output | NUM_DEV | Tri-state read enable per unguarded device |
| shr_q | output | NUM_DEV*DATA_W | Held data per device, device i at slice i |
| dec_err | output | 1 | Unknown select code on an I/O access |

## Verification
The assertions check, on every cycle, the properties that relate ports to each other. Non-I/O cycles and unknown codes stay quiet, at most one enable is active, read enables appear only with a read strobe, control bits never accompany a guard-enable, and the holding registers either load the write data or keep their value. Which device a given select pattern maps to in each encoding can only be shown by the bench's scenarios. The bench runs three instances, one per encoding, on the same address stream. The same holds for the exact control field passed on and the value a device keeps across a sequence of writes to other devices and reads.

// File: rtl/mmio_sel_pkg.sv
`timescale 1ns/1ps
package mmio_sel_pkg;

    typedef enum logic [1:0] {
        SEL_ONEHOT = 2'd0,
        SEL_BINARY = 2'd1,
        SEL_PREFIX = 2'd2
    } sel_mode_e;

    // Width of the select field for a given encoding.
    function automatic int sel_width(sel_mode_e mode, int n_dev, int pfx_w);
        int w;
        case (mode)
            SEL_ONEHOT: w = n_dev;
            SEL_BINARY: w = (n_dev <= 2) ? 1 : $clog2(n_dev);
            default:    w = pfx_w;
        endcase
        return w;
    endfunction

    // Mask that keeps the top 'len' bits of a pfx_w wide field.
    function automatic int pfx_mask(int len, int pfx_w);
        return ((1 << len) - 1) << (pfx_w - len);
    endfunction

endpackage

// File: rtl/mmio_addr_split.sv
`timescale 1ns/1ps
module mmio_addr_split #(
    parameter int ADDR_W = 16,
    parameter int IO_BIT = 15,
    parameter int SEL_W  = 4,
    parameter int CTRL_W = 4,
    localparam int FLD_W = 1 + SEL_W + CTRL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [FLD_W-1:0]  fld
);
    // Field order: io flag, select field, control field.
    assign fld = {addr[IO_BIT], addr[IO_BIT-1 -: SEL_W], addr[CTRL_W-1:0]};

    logic unused_addr_bits;
    assign unused_addr_bits = ^addr;
endmodule

// File: rtl/mmio_sel_decode.sv
`timescale 1ns/1ps
module mmio_sel_decode
    import mmio_sel_pkg::*;
#(
    parameter sel_mode_e MODE    = SEL_PREFIX,
    parameter int        NUM_DEV = 4,
    parameter int        SEL_W   = 4,
    parameter int        PFX_W   = 4,
    parameter logic [NUM_DEV-1:0][PFX_W-1:0] PFX_CODE = '0,
    parameter logic [NUM_DEV-1:0][7:0]       PFX_LEN  = '0
) (
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_DEV-1:0] hit,
    output logic               err
);
    generate
        if (MODE == SEL_ONEHOT) begin : g_onehot
            assign hit = $onehot(sel) ? sel : '0;
            assign err = !$onehot(sel);
        end else if (MODE == SEL_BINARY) begin : g_binary
            for (genvar i = 0; i < NUM_DEV; i++) begin : g_cmp
                assign hit[i] = (sel == SEL_W'(i));
            end
            assign err = (int'(sel) >= NUM_DEV);
        end else begin : g_prefix
            logic [NUM_DEV-1:0] match;
            for (genvar i = 0; i < NUM_DEV; i++) begin : g_cmp
                localparam logic [PFX_W-1:0] MSK =
                    PFX_W'(pfx_mask(int'(PFX_LEN[i]), PFX_W));
                assign match[i] = ((sel ^ PFX_CODE[i]) & MSK) == '0;
            end
            // Longest matching code wins, so a table that is not prefix-free
            // still resolves to a single device.
            always_comb begin
                int best_len;
                best_len = 0;
                hit      = '0;
                err      = 1'b1;
                for (int i = 0; i < NUM_DEV; i++) begin
                    if (match[i] && int'(PFX_LEN[i]) > best_len) begin
                        best_len = int'(PFX_LEN[i]);
                        hit      = '0;
                        hit[i]   = 1'b1;
                        err      = 1'b0;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/mmio_share_latch.sv
`timescale 1ns/1ps
module mmio_share_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (ld) q <= d;
    end

    // R7: a load strobe captures the bus data
    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        ld |=> (q == $past(d)));

    // R8: without a load the held value does not move
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(q));
endmodule

// File: rtl/mmio_sel_decoder.sv
`timescale 1ns/1ps
module mmio_sel_decoder
    import mmio_sel_pkg::*;
#(
    parameter int        ADDR_W  = 16,
    parameter int        DATA_W  = 8,
    parameter int        NUM_DEV = 4,
    parameter int        CTRL_W  = 4,
    parameter int        IO_BIT  = ADDR_W - 1,
    parameter int        PFX_W   = 4,
    parameter sel_mode_e MODE    = SEL_PREFIX,
    parameter logic [NUM_DEV-1:0] GUARD_MASK = 4'b0101,
    parameter logic [NUM_DEV-1:0][PFX_W-1:0] PFX_CODE =
        {4'b1110, 4'b1100, 4'b1000, 4'b0000},
    parameter logic [NUM_DEV-1:0][7:0] PFX_LEN =
        {8'd4, 8'd3, 8'd2, 8'd1}
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr_stb,
    input  logic                      rd_stb,
    input  logic [DATA_W-1:0]         wdata,
    output logic [NUM_DEV-1:0]        guard_en,
    output logic [CTRL_W-1:0]         dev_ctrl,
    output logic [NUM_DEV-1:0]        shr_oe,
    output logic [NUM_DEV*DATA_W-1:0] shr_q,
    output logic                      dec_err
);
    localparam int SEL_W = sel_width(MODE, NUM_DEV, PFX_W);
    localparam int FLD_W = 1 + SEL_W + CTRL_W;

    typedef struct packed {
        logic              io;
        logic [SEL_W-1:0]  sel;
        logic [CTRL_W-1:0] ctrl;
    } fld_t;

    logic [FLD_W-1:0]   fld_raw;
    fld_t               f;
    logic [NUM_DEV-1:0] hit_raw, hit, sh_hit, ld;
    logic               err_raw;

    mmio_addr_split #(
        .ADDR_W (ADDR_W),
        .IO_BIT (IO_BIT),
        .SEL_W  (SEL_W),
        .CTRL_W (CTRL_W)
    ) u_split (
        .addr (addr),
        .fld  (fld_raw)
    );

    assign f = fld_t'(fld_raw);

    mmio_sel_decode #(
        .MODE     (MODE),
        .NUM_DEV  (NUM_DEV),
        .SEL_W    (SEL_W),
        .PFX_W    (PFX_W),
        .PFX_CODE (PFX_CODE),
        .PFX_LEN  (PFX_LEN)
    ) u_dec (
        .sel (f.sel),
        .hit (hit_raw),
        .err (err_raw)
    );

    // Only I/O cycles may select anything.
    assign hit      = f.io ? hit_raw : '0;
    assign dec_err  = f.io & err_raw;
    assign guard_en = hit & GUARD_MASK;
    assign sh_hit   = hit & ~GUARD_MASK;
    assign shr_oe   = rd_stb ? sh_hit : '0;
    assign ld       = wr_stb ? sh_hit : '0;
    assign dev_ctrl = (|sh_hit) ? f.ctrl : '0;

    generate
        for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
            if (GUARD_MASK[i]) begin : g_guarded
                assign shr_q[i*DATA_W +: DATA_W] = '0;
            end else begin : g_shared
                mmio_share_latch #(.DATA_W(DATA_W)) u_hold (
                    .clk (clk),
                    .rst (rst),
                    .ld  (ld[i]),
                    .d   (wdata),
                    .q   (shr_q[i*DATA_W +: DATA_W])
                );
            end
        end
    endgenerate

    // R1: non-I/O cycles leave every device untouched
    p_no_io_r1: assert property (@(posedge clk) disable iff (rst)
        !addr[IO_BIT] |-> (guard_en == '0 && shr_oe == '0 && !dec_err && dev_ctrl == '0));

    // R5: at most one enable of any kind
    p_one_enable_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({guard_en, shr_oe}));

    // R6: control bits never accompany a guarded selection
    p_ctrl_guard_r6: assert property (@(posedge clk) disable iff (rst)
        (guard_en != '0) |-> (dev_ctrl == '0));

    // R9: tri-state enables only during a read
    p_oe_read_r9: assert property (@(posedge clk) disable iff (rst)
        (shr_oe != '0) |-> rd_stb);

    // R10: an unknown code selects nothing
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        dec_err |-> (guard_en == '0 && shr_oe == '0 && dev_ctrl == '0));
endmodule

// File: tb/mmio_sel_decoder_bench.sv
`timescale 1ns/1ps
module mmio_sel_decoder_bench;
    import mmio_sel_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        rst;
    logic [15:0] addr;
    logic        wr_stb, rd_stb;
    logic [7:0]  wdata;

    logic [3:0]  g_p, o_p, c_p, g_h, o_h, c_h, c_b;
    logic [2:0]  g_b, o_b;
    logic [31:0] q_p, q_h;
    logic [23:0] q_b;
    logic        e_p, e_h, e_b;

    // Prefix-code instance (defaults), guarded devices 0 and 2
    mmio_sel_decoder u_mmio_sel_decoder (
        .clk(clk), .rst(rst), .addr(addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(wdata), .guard_en(g_p), .dev_ctrl(c_p), .shr_oe(o_p),
        .shr_q(q_p), .dec_err(e_p));

    // One-hot instance, guarded devices 0 and 1
    mmio_sel_decoder #(.MODE(SEL_ONEHOT), .GUARD_MASK(4'b0011)) u_onehot (
        .clk(clk), .rst(rst), .addr(addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(wdata), .guard_en(g_h), .dev_ctrl(c_h), .shr_oe(o_h),
        .shr_q(q_h), .dec_err(e_h));

    // Binary instance, three devices, guarded device 1
    mmio_sel_decoder #(
        .MODE(SEL_BINARY), .NUM_DEV(3), .GUARD_MASK(3'b010),
        .PFX_CODE({4'b1100, 4'b1000, 4'b0000}),
        .PFX_LEN({8'd3, 8'd2, 8'd1})
    ) u_binary (
        .clk(clk), .rst(rst), .addr(addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(wdata), .guard_en(g_b), .dev_ctrl(c_b), .shr_oe(o_b),
        .shr_q(q_b), .dec_err(e_b));

    typedef struct packed {
        logic [3:0]  g;
        logic [3:0]  oe;
        logic [3:0]  ctrl;
        logic        err;
        logic [31:0] q;
    } exp_t;

    typedef struct packed {
        exp_t p;
        exp_t h;
        exp_t b;
    } item_t;

    item_t sbq[$];
    string tagq[$];
    logic [7:0] lat [3][4];     // model of held data: [instance][device]
    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // mode: 0 prefix, 1 one-hot, 2 binary (3 devices)
    function automatic int dev_of(int mode, logic [15:0] a, output bit err);
        logic [3:0] f;
        err = 0;
        f = a[14:11];
        if (!a[15]) return -1;
        if (mode == 0) begin
            if (!f[3]) return 0;
            if (!f[2]) return 1;
            if (!f[1]) return 2;
            if (!f[0]) return 3;
            err = 1;
            return -1;
        end else if (mode == 1) begin
            if ($countones(f) != 1) begin err = 1; return -1; end
            for (int i = 0; i < 4; i++) if (f[i]) return i;
            return -1;
        end else begin
            if (a[14:13] == 2'd3) begin err = 1; return -1; end
            return int'(a[14:13]);
        end
    endfunction

    function automatic exp_t predict(int mode, logic [3:0] gmask, logic [15:0] a,
                                     bit wr, bit rd, logic [7:0] wd);
        exp_t e;
        bit   er;
        int   d;
        int   nd;
        e  = '0;
        nd = (mode == 2) ? 3 : 4;
        d  = dev_of(mode, a, er);
        e.err = er;
        if (d >= 0) begin
            if (gmask[d]) e.g[d] = 1'b1;
            else begin
                e.ctrl = a[3:0];
                if (rd) e.oe[d] = 1'b1;
                if (wr) lat[mode][d] = wd;
            end
        end
        for (int i = 0; i < nd; i++) e.q[i*8 +: 8] = lat[mode][i];
        return e;
    endfunction

    task automatic apply(logic [15:0] a, bit wr, bit rd, logic [7:0] wd, string tag);
        item_t it;
        @(negedge clk);
        addr = a; wr_stb = wr; rd_stb = rd; wdata = wd;
        it.p = predict(0, 4'b0101, a, wr, rd, wd);
        it.h = predict(1, 4'b0011, a, wr, rd, wd);
        it.b = predict(2, 4'b0010, a, wr, rd, wd);
        sbq.push_back(it);
        tagq.push_back(tag);
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: compares one item per clock, one time unit after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                item_t it;
                string t;
                it = sbq.pop_front();
                t  = tagq.pop_front();
                chk(t, "prefix guard_en", {28'd0, g_p}, {28'd0, it.p.g});
                chk(t, "prefix shr_oe",   {28'd0, o_p}, {28'd0, it.p.oe});
                chk(t, "prefix dev_ctrl", {28'd0, c_p}, {28'd0, it.p.ctrl});
                chk(t, "prefix dec_err",  {31'd0, e_p}, {31'd0, it.p.err});
                chk(t, "prefix shr_q",    q_p,          it.p.q);
                chk(t, "onehot guard_en", {28'd0, g_h}, {28'd0, it.h.g});
                chk(t, "onehot shr_oe",   {28'd0, o_h}, {28'd0, it.h.oe});
                chk(t, "onehot dev_ctrl", {28'd0, c_h}, {28'd0, it.h.ctrl});
                chk(t, "onehot dec_err",  {31'd0, e_h}, {31'd0, it.h.err});
                chk(t, "onehot shr_q",    q_h,          it.h.q);
                chk(t, "binary guard_en", {29'd0, g_b}, {28'd0, it.b.g});
                chk(t, "binary shr_oe",   {29'd0, o_b}, {28'd0, it.b.oe});
                chk(t, "binary dev_ctrl", {28'd0, c_b}, {28'd0, it.b.ctrl});
                chk(t, "binary dec_err",  {31'd0, e_b}, {31'd0, it.b.err});
                chk(t, "binary shr_q",    {8'd0, q_b},  it.b.q);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 3; m++)
            for (int d = 0; d < 4; d++) lat[m][d] = 8'h00;
        rst = 1'b1; addr = '0; wr_stb = 0; rd_stb = 0; wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        apply(16'h7FFF, 1, 1, 8'hAA, "R1 R11");     // non-I/O with both strobes; registers still 0
        apply(16'h8005, 0, 0, 8'h00, "R4 R5 R2");   // prefix dev0 guarded; one-hot all-zero field
        apply(16'hC00A, 1, 0, 8'h11, "R4 R6 R7");   // prefix dev1, one-hot dev3, binary dev2 loads
        apply(16'hC00A, 0, 1, 8'h22, "R8 R9");      // read: enables, no load
        apply(16'hE003, 1, 0, 8'h33, "R4 R5 R10");  // prefix dev2 guarded; binary code 3 unknown
        apply(16'hF00C, 1, 1, 8'h44, "R4 R7 R9");   // prefix dev3 loads and reads
        apply(16'hF80F, 1, 1, 8'h55, "R4 R10");     // prefix 1111 unknown
        apply(16'h8800, 1, 0, 8'h66, "R2 R3");      // one-hot dev0, binary dev0 loads
        apply(16'h9007, 1, 1, 8'h77, "R2 R6");      // one-hot dev1 guarded
        apply(16'hA009, 1, 0, 8'h88, "R2 R3 R7");   // one-hot dev2 loads, binary dev1 guarded
        apply(16'h2009, 1, 1, 8'h99, "R1 R8");      // non-I/O write is ignored
        apply(16'hC00B, 0, 0, 8'hEE, "R6 R8");      // idle select, no strobes
        apply(16'hF80A, 0, 1, 8'h00, "R10");        // unknown code on a read
        apply(16'hB801, 1, 1, 8'h5A, "R2 R3 R10");  // one-hot multi-bit, binary dev1

        wait (sbq.size() == 0);
        @(posedge clk);
        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule